// File: doc/BRIEF.md
# Dual-Channel Keyboard Controller Host Port

This block is the processor-facing side of a PC-style keyboard controller. Two receive channels feed it: a keyboard channel and an auxiliary (pointing device) channel. Each one offers a byte with a one-cycle valid strobe. The block keeps each byte until the host reads it and records which channels hold unread data. When both hold data it presents the keyboard byte first.

The host sees two byte-wide ports. The data port returns the presented byte, and a write to it can update the mode byte. The other port returns a status byte on read and takes command bytes on write. One address bit, picked by a parameter mask, chooses between the two ports. With the default mask the data port sits at offset 0x60 and the status/command port at 0x64. The block also drives two level interrupts, one per channel, and recomputes them from the pending mask and the mode byte.

Top module: `kbc_hostport`

## Requirements
- R1: A synchronous active-high reset sets the mode byte to 0x03, clears the pending mask and both interrupts, and sets the status byte to 0x18.
- R2: An access whose address ANDed with `SEL_MASK` (default 0x04) is nonzero goes to the status/command port. Any other access goes to the data port. With the defaults, 0x64 and 0x6C read status, and 0x60 and 0x61 read data.
- R3: A valid strobe on either channel sets that channel's pending bit (bit 0 keyboard, bit 1 auxiliary). Status bit 0 is 1 while any pending bit is set and 0 when none is set.
- R4: When both channels are pending, a data read returns the keyboard byte and status bit 5 stays 0.
- R5: Status bit 5 is 1 only when the auxiliary channel alone is pending. In that state `irq_aux` equals mode bit 1.
- R6: `irq_kb` is high exactly when keyboard data is pending, mode bit 0 is 1 and mode bit 4 is 0. The two interrupts are never high together.
- R7: A data read clears the pending bit of the channel whose byte it returned. A data read with nothing pending returns the byte that the previous data read returned.
- R8: A new byte on a channel that is already pending replaces the held byte, and the pending bit stays set.
- R9: Command 0x20 places the current mode byte in the keyboard holding register and marks keyboard data pending.
- R10: Command 0x60 arms the next data-port write to store into the mode byte. A data-port write that is not armed leaves the mode byte unchanged.
- R11: A command write sets status bit 3 and a data write clears it. Status bit 4 always reads 1. A command byte other than 0x20 or 0x60 changes nothing else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Bus access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address, port chosen by `SEL_MASK` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational, 0 when `cs` is low) |
| kb_valid | input | 1 | Keyboard byte strobe |
| kb_byte | input | 8 | Keyboard received byte |
| aux_valid | input | 1 | Auxiliary byte strobe |
| aux_byte | input | 8 | Auxiliary received byte |
| irq_kb | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |

## Verification
Read data comes straight from registers, so the bench samples `rdata` one nanosecond after it drives a read strobe. This is in the same cycle and before the edge where the read clears a pending bit. A channel strobe, a command or a mode write lands at the next rising edge. The status byte and both interrupt levels follow without further delay, so each scenario drives on a falling edge and checks them at the next falling edge. The both-pending case is checked twice: once before the first read to confirm keyboard priority, and once after it to confirm that the auxiliary-only state shows up.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int DW   = 8;
    localparam int N_CH = 2;
    localparam int CH_KB  = 0;
    localparam int CH_AUX = 1;

    typedef logic [DW-1:0]   byte_t;
    typedef logic [N_CH-1:0] pend_t;

    // pending mask values
    localparam pend_t PEND_AUX_ONLY = 2'b10;

    // mode bit positions
    localparam int MB_KB_IE  = 0;
    localparam int MB_AUX_IE = 1;
    localparam int MB_KB_DIS = 4;

    // status bit positions
    localparam int SB_OBF  = 0;
    localparam int SB_CMD  = 3;
    localparam int SB_UNLK = 4;
    localparam int SB_AUXF = 5;

    localparam byte_t CMD_RD_MODE = 8'h20;
    localparam byte_t CMD_WR_MODE = 8'h60;
    localparam byte_t MODE_RST    = 8'h03;

    typedef struct packed {
        logic data_rd;
        logic data_wr;
        logic ctl_wr;
        logic stat_sel;
    } port_req_t;

    function automatic logic aux_alone(input pend_t p);
        return p == PEND_AUX_ONLY;
    endfunction

    function automatic byte_t make_status(input pend_t p, input logic cmd);
        byte_t s;
        s           = '0;
        s[SB_OBF]   = |p;
        s[SB_CMD]   = cmd;
        s[SB_UNLK]  = 1'b1;
        s[SB_AUXF]  = aux_alone(p);
        return s;
    endfunction

endpackage

// File: rtl/kbc_port_dec.sv
module kbc_port_dec
    import kbc_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SEL_MASK = 8'h04
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output port_req_t         req
);
    logic ctl_side;

    always_comb begin
        ctl_side     = |(addr & SEL_MASK);
        req.stat_sel = ctl_side;
        req.data_rd  = cs && !we && !ctl_side;
        req.data_wr  = cs &&  we && !ctl_side;
        req.ctl_wr   = cs &&  we &&  ctl_side;
    end
endmodule

// File: rtl/kbc_ctl_regs.sv
module kbc_ctl_regs
    import kbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_req_t req,
    input  byte_t     wdata,
    output byte_t     mode_q,
    output logic      cmd_q,
    output logic      rsp_load
);
    logic arm_q;

    assign rsp_load = req.ctl_wr && (wdata == CMD_RD_MODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RST;
            arm_q  <= 1'b0;
            cmd_q  <= 1'b1;
        end else begin
            if (req.ctl_wr) begin
                cmd_q <= 1'b1;
                arm_q <= (wdata == CMD_WR_MODE);
            end else if (req.data_wr) begin
                cmd_q <= 1'b0;
                arm_q <= 1'b0;
                if (arm_q) begin
                    mode_q <= wdata;
                end
            end
        end
    end
endmodule

// File: rtl/kbc_chan_buf.sv
module kbc_chan_buf
    import kbc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CH-1:0]      in_valid,
    input  logic [N_CH-1:0][7:0] in_byte,
    input  logic                 data_rd,
    input  logic                 rsp_load,
    input  byte_t                mode_q,
    output pend_t                pend_q,
    output byte_t                data_out
);
    logic [N_CH-1:0][7:0] hold_q;
    logic [N_CH-1:0]      load_en;
    logic [N_CH-1:0][7:0] load_val;
    logic [N_CH-1:0]      clr;
    byte_t                last_q;
    byte_t                shown;
    logic                 pick_aux;

    assign pick_aux = aux_alone(pend_q);
    assign shown    = pick_aux ? hold_q[CH_AUX] : hold_q[CH_KB];
    assign data_out = (pend_q == '0) ? last_q : shown;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        if (c == CH_KB) begin : g_kb
            // command response shares the keyboard output path
            assign load_en[c]  = in_valid[c] || rsp_load;
            assign load_val[c] = rsp_load ? mode_q : in_byte[c];
            assign clr[c]      = data_rd && pend_q[c];
        end else begin : g_other
            assign load_en[c]  = in_valid[c];
            assign load_val[c] = in_byte[c];
            assign clr[c]      = data_rd && pick_aux;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[c] <= 1'b0;
                hold_q[c] <= '0;
            end else begin
                pend_q[c] <= (pend_q[c] && !clr[c]) || load_en[c];
                if (load_en[c]) begin
                    hold_q[c] <= load_val[c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
        end else if (data_rd && (pend_q != '0)) begin
            last_q <= shown;
        end
    end
endmodule

// File: rtl/kbc_irq_stat.sv
module kbc_irq_stat
    import kbc_pkg::*;
(
    input  pend_t pend_q,
    input  byte_t mode_q,
    input  logic  cmd_q,
    output byte_t status,
    output logic  irq_kb,
    output logic  irq_aux
);
    logic aux_sole;

    assign aux_sole = aux_alone(pend_q);
    assign status   = make_status(pend_q, cmd_q);
    assign irq_kb   = pend_q[CH_KB] && mode_q[MB_KB_IE] && !mode_q[MB_KB_DIS];
    assign irq_aux  = aux_sole && mode_q[MB_AUX_IE];
endmodule

// File: rtl/kbc_hostport.sv
module kbc_hostport
    import kbc_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SEL_MASK = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              kb_valid,
    input  logic [7:0]        kb_byte,
    input  logic              aux_valid,
    input  logic [7:0]        aux_byte,
    output logic              irq_kb,
    output logic              irq_aux
);
    port_req_t            req;
    byte_t                mode_q;
    logic                 cmd_q;
    logic                 rsp_load;
    pend_t                pend_q;
    byte_t                data_out;
    byte_t                stat_b;
    logic [N_CH-1:0]      in_valid;
    logic [N_CH-1:0][7:0] in_byte;

    assign in_valid[CH_KB]  = kb_valid;
    assign in_valid[CH_AUX] = aux_valid;
    assign in_byte[CH_KB]   = kb_byte;
    assign in_byte[CH_AUX]  = aux_byte;

    kbc_port_dec #(.ADDR_W(ADDR_W), .SEL_MASK(SEL_MASK)) u_dec (
        .cs(cs), .we(we), .addr(addr), .req(req)
    );

    kbc_ctl_regs u_ctl (
        .clk(clk), .rst(rst), .req(req), .wdata(wdata),
        .mode_q(mode_q), .cmd_q(cmd_q), .rsp_load(rsp_load)
    );

    kbc_chan_buf u_buf (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .data_rd(req.data_rd), .rsp_load(rsp_load), .mode_q(mode_q),
        .pend_q(pend_q), .data_out(data_out)
    );

    kbc_irq_stat u_irq (
        .pend_q(pend_q), .mode_q(mode_q), .cmd_q(cmd_q),
        .status(stat_b), .irq_kb(irq_kb), .irq_aux(irq_aux)
    );

    always_comb begin
        if (!cs)               rdata = '0;
        else if (req.stat_sel) rdata = stat_b;
        else                   rdata = data_out;
    end
endmodule

// File: rtl/kbc_hostport_chk.sv
module kbc_hostport_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] status_o,
    input logic [7:0] mode_q,
    input logic [1:0] pend_q,
    input logic       kb_valid,
    input logic       aux_valid,
    input logic       data_rd,
    input logic       irq_kb,
    input logic       irq_aux
);
    p_unlocked_r11: assert property (@(posedge clk) disable iff (rst)
        status_o[4]);

    p_irq_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(irq_kb && irq_aux));

    p_kb_gate_r6: assert property (@(posedge clk) disable iff (rst)
        irq_kb |-> (mode_q[0] && !mode_q[4] && pend_q[0]));

    p_auxfull_r4: assert property (@(posedge clk) disable iff (rst)
        status_o[5] |-> (!irq_kb && status_o[0]));

    p_obf_set_r3: assert property (@(posedge clk) disable iff (rst)
        (kb_valid || aux_valid) |=> status_o[0]);

    p_aux_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_q == 2'b10 && mode_q[1]) |-> irq_aux);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (pend_q[1] && !(data_rd && pend_q == 2'b10)) |=> pend_q[1]);
endmodule

bind kbc_hostport kbc_hostport_chk u_chk (
    .clk(clk), .rst(rst), .status_o(stat_b), .mode_q(mode_q),
    .pend_q(pend_q), .kb_valid(kb_valid), .aux_valid(aux_valid),
    .data_rd(req.data_rd), .irq_kb(irq_kb), .irq_aux(irq_aux)
);

// File: tb/kbc_hostport_bench.sv
`timescale 1ns/1ps
module kbc_hostport_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, we = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       kb_valid = 1'b0, aux_valid = 1'b0;
    logic [7:0] kb_byte = 8'h00, aux_byte = 8'h00;
    logic       irq_kb, irq_aux;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    localparam logic [7:0] A_DATA = 8'h60;
    localparam logic [7:0] A_CTL  = 8'h64;

    always #10 clk = ~clk;

    kbc_hostport u_kbc_hostport (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .kb_valid(kb_valid), .kb_byte(kb_byte),
        .aux_valid(aux_valid), .aux_byte(aux_byte),
        .irq_kb(irq_kb), .irq_aux(irq_aux)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
        #1 v = rdata;
        @(negedge clk); cs = 1'b0;
    endtask

    task automatic push(input logic kb, input logic [7:0] kv, input logic ax, input logic [7:0] av);
        @(negedge clk); kb_valid = kb; kb_byte = kv; aux_valid = ax; aux_byte = av;
        @(negedge clk); kb_valid = 1'b0; aux_valid = 1'b0;
    endtask

    task automatic check_irq(input string tag, input logic k, input logic a);
        check({tag, " irq_kb"}, {7'd0, irq_kb}, {7'd0, k});
        check({tag, " irq_aux"}, {7'd0, irq_aux}, {7'd0, a});
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_rd(A_CTL, v);  check("R1 status after reset", v, 8'h18);
        check_irq("R1", 1'b0, 1'b0);
        bus_wr(A_CTL, 8'h20);
        bus_rd(A_CTL, v);  check("R9 status after 0x20", v, 8'h19);
        check_irq("R9 mode 0x03 kb irq", 1'b1, 1'b0);
        bus_rd(A_DATA, v); check("R1 reset mode via R9", v, 8'h03);
        bus_rd(A_CTL, v);  check("R7 status after read", v, 8'h18);
    endtask

    task automatic t_decode();
        logic [7:0] v;
        push(1'b1, 8'h7E, 1'b0, 8'h00);
        bus_rd(8'h6C, v); check("R2 0x6C is status", v, 8'h19);
        bus_rd(8'h64, v); check("R2 0x64 is status", v, 8'h19);
        bus_rd(8'h61, v); check("R2 0x61 is data", v, 8'h7E);
        bus_rd(8'h60, v); check("R2 R7 empty read repeats", v, 8'h7E);
    endtask

    task automatic t_kb();
        logic [7:0] v;
        push(1'b1, 8'hA5, 1'b0, 8'h00);
        check_irq("R6 kb pending", 1'b1, 1'b0);
        bus_rd(A_CTL, v);  check("R3 obf set", v, 8'h19);
        bus_rd(A_DATA, v); check("R7 kb byte", v, 8'hA5);
        check_irq("R7 after read", 1'b0, 1'b0);
        bus_rd(A_CTL, v);  check("R3 obf clear", v, 8'h18);
        bus_rd(A_DATA, v); check("R7 empty read last byte", v, 8'hA5);
    endtask

    task automatic t_aux();
        logic [7:0] v;
        push(1'b0, 8'h00, 1'b1, 8'h5A);
        check_irq("R5 aux alone", 1'b0, 1'b1);
        bus_rd(A_CTL, v);  check("R5 aux full", v, 8'h39);
        bus_rd(A_DATA, v); check("R7 aux byte", v, 8'h5A);
        bus_rd(A_CTL, v);  check("R7 aux cleared", v, 8'h18);
        check_irq("R5 after read", 1'b0, 1'b0);
    endtask

    task automatic t_both();
        logic [7:0] v;
        push(1'b1, 8'h11, 1'b1, 8'h22);
        check_irq("R4 both pending", 1'b1, 1'b0);
        bus_rd(A_CTL, v);  check("R4 aux flag clear", v, 8'h19);
        bus_rd(A_DATA, v); check("R4 kb priority", v, 8'h11);
        bus_rd(A_CTL, v);  check("R4 aux remains", v, 8'h39);
        check_irq("R4 aux alone now", 1'b0, 1'b1);
        bus_rd(A_DATA, v); check("R4 aux second", v, 8'h22);
    endtask

    task automatic t_overwrite();
        logic [7:0] v;
        push(1'b1, 8'h33, 1'b0, 8'h00);
        push(1'b1, 8'h44, 1'b0, 8'h00);
        bus_rd(A_CTL, v);  check("R8 still pending", v, 8'h19);
        bus_rd(A_DATA, v); check("R8 newest byte", v, 8'h44);
        bus_rd(A_CTL, v);  check("R8 one read empties", v, 8'h18);
        push(1'b0, 8'h00, 1'b1, 8'h66);
        push(1'b0, 8'h00, 1'b1, 8'h77);
        bus_rd(A_DATA, v); check("R8 aux newest", v, 8'h77);
        bus_rd(A_CTL, v);  check("R8 aux empty", v, 8'h18);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        bus_wr(A_CTL, 8'h60);
        bus_wr(A_DATA, 8'h10);
        bus_rd(A_CTL, v); check("R11 data write clears cmd bit", v, 8'h10);
        push(1'b1, 8'h55, 1'b0, 8'h00);
        check_irq("R6 kb disabled", 1'b0, 1'b0);
        bus_rd(A_DATA, v); check("R10 R6 byte", v, 8'h55);
        push(1'b0, 8'h00, 1'b1, 8'h56);
        check_irq("R5 aux ie clear", 1'b0, 1'b0);
        bus_rd(A_DATA, v); check("R5 aux byte", v, 8'h56);
        bus_wr(A_CTL, 8'h60);
        bus_wr(A_DATA, 8'h11);
        push(1'b1, 8'h57, 1'b0, 8'h00);
        check_irq("R6 ie set but disabled", 1'b0, 1'b0);
        bus_rd(A_DATA, v); check("R6 byte", v, 8'h57);
        bus_wr(A_CTL, 8'h60);
        bus_wr(A_DATA, 8'h01);
        push(1'b1, 8'h58, 1'b0, 8'h00);
        check_irq("R6 kb ie only", 1'b1, 1'b0);
        bus_rd(A_DATA, v); check("R6 byte 2", v, 8'h58);
        bus_wr(A_DATA, 8'hFF);
        bus_wr(A_CTL, 8'h20);
        bus_rd(A_DATA, v); check("R10 unarmed write ignored", v, 8'h01);
        bus_wr(A_CTL, 8'hAA);
        bus_rd(A_CTL, v); check("R11 other cmd sets cmd bit", v, 8'h18);
        bus_wr(A_DATA, 8'hC3);
        bus_rd(A_CTL, v); check("R11 data write", v, 8'h10);
        bus_wr(A_CTL, 8'h20);
        bus_rd(A_DATA, v); check("R11 R10 cmd 0xAA left mode", v, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_kb();
        t_aux();
        t_both();
        t_overwrite();
        t_mode();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule